// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the low address bits of a four-beat memory burst. When an access starts, the low bits of the external address are captured as the start point. Each later beat is then produced on chip from that start point and a beat count. A static ordering input picks one of two sequences. The interleaved sequence flips bits of the start address. The linear sequence counts upward from the start and wraps within the aligned group of four.

An active-low advance strobe steps the burst by one beat on a rising edge. While the strobe is high the burst waits, and the same address is presented again. A new start address can be loaded on any edge, and it replaces any burst in progress. The upper address bits do not pass through this block.

Top module: `burst_seq_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the stored start address and the beat index, so `burst_addr_o` and `beat_o` both read 0 after that edge.
- R2: When `load_i` is high at a rising edge, the next outputs are `burst_addr_o` = the sampled `start_addr_i` and `beat_o` = 0. This holds for both orderings.
- R3: A load has priority over the advance strobe. If `load_i` is high and `adv_n_i` is low on the same edge, the burst restarts at the new address with beat 0, whatever burst was in progress.
- R4: With `mode_i` = 1 (interleaved), the output is the start address XOR the beat index. Starts 0,1,2,3 give the sequences 0-1-2-3, 1-0-3-2, 2-3-0-1 and 3-2-1-0.
- R5: With `mode_i` = 0 (linear), the output is the start address plus the beat index, modulo 4. Starts 0,1,2,3 give the sequences 0-1-2-3, 1-2-3-0, 2-3-0-1 and 3-0-1-2.
- R6: When `adv_n_i` is high and `load_i` is low at an edge, the beat index and the address do not change (wait cycle).
- R7: An advance after the fourth beat wraps the beat index from 3 to 0, so the address returns to the start address.
- R8: `mode_i` is not registered. A change of `mode_i` remaps the current beat at once, without a clock edge and without touching the beat index.
- R9: Each edge with `adv_n_i` low and `load_i` low raises `beat_o` by exactly one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start a new burst from `start_addr_i` |
| start_addr_i | input | ADDR_W (2) | External low address bits of the first beat |
| adv_n_i | input | 1 | Advance strobe, active low; high means wait |
| mode_i | input | 1 | Ordering: 1 interleaved, 0 linear |
| burst_addr_o | output | ADDR_W (2) | Low address bits of the current beat |
| beat_o | output | ADDR_W (2) | Beat index of the current beat |

## Verification
Every output comes from two registers, the start address and the beat index, through one combinational mapping. A corrupted register therefore shows at the ports on the first edge after the fault. A wrong beat index breaks the step-by-one rule, or makes `beat_o` move during a wait. A wrong start register makes the beat-0 address differ from the address loaded. A fault in the mapping shows only in the ordering it affects. For that reason, every start value is walked through a full burst and its wrap in both modes, and the mode is switched in the middle of a burst. An XOR slipped in where an add belongs, or the reverse, is then seen within one beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   // Ordering selected by the static mode input
   typedef enum logic {
      ORD_LINEAR      = 1'b0,
      ORD_INTERLEAVED = 1'b1
   } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] din,
   output logic [ADDR_W-1:0] start_q
);
   always_ff @(posedge clk) begin
      if (rst)
         start_q <= '0;
      else if (load)
         start_q <= din;
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              step,
   output logic [ADDR_W-1:0] beat_q
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   // load clears the count and wins over step
   always_ff @(posedge clk) begin
      if (rst)
         beat_q <= '0;
      else if (load)
         beat_q <= '0;
      else if (step)
         beat_q <= beat_q + ONE;
   end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic [ADDR_W-1:0] start_q,
   input  logic [ADDR_W-1:0] beat_q,
   input  order_e            order,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] flip_addr;
   logic [ADDR_W-1:0] wrap_addr;
   logic [ADDR_W:0]   carry;

   assign carry[0] = 1'b0;

   // one bit slice per address bit: xor term and ripple-sum term
   for (genvar i = 0; i < ADDR_W; i++) begin : g_slice
      assign flip_addr[i] = start_q[i] ^ beat_q[i];
      assign wrap_addr[i] = start_q[i] ^ beat_q[i] ^ carry[i];
      assign carry[i+1]   = (start_q[i] & beat_q[i]) |
                            (carry[i] & (start_q[i] ^ beat_q[i]));
   end

   // the final carry is dropped: the sum wraps modulo the burst length
   always_comb begin
      if (order == ORD_INTERLEAVED)
         addr = flip_addr;
      else
         addr = wrap_addr;
   end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              adv_n_i,
   input  logic              mode_i,
   output logic [ADDR_W-1:0] burst_addr_o,
   output logic [ADDR_W-1:0] beat_o
);
   localparam int BEATS = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 4) begin : g_bad_width
      $error("burst_seq_gen: ADDR_W must be 1..4");
   end
   if (BEATS != (1 << ADDR_W)) begin : g_bad_beats
      $error("burst_seq_gen: BEATS inconsistent with ADDR_W");
   end

   logic [ADDR_W-1:0] start_q;
   logic [ADDR_W-1:0] beat_q;
   order_e            order;

   assign order = order_e'(mode_i);

   burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk     (clk),
      .rst     (rst),
      .load    (load_i),
      .din     (start_addr_i),
      .start_q (start_q)
   );

   burst_beat_ctr #(.ADDR_W(ADDR_W)) u_beat (
      .clk    (clk),
      .rst    (rst),
      .load   (load_i),
      .step   (~adv_n_i),
      .beat_q (beat_q)
   );

   burst_addr_map #(.ADDR_W(ADDR_W)) u_map (
      .start_q (start_q),
      .beat_q  (beat_q),
      .order   (order),
      .addr    (burst_addr_o)
   );

   assign beat_o = beat_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              load_i,
   input logic [ADDR_W-1:0] start_addr_i,
   input logic              adv_n_i,
   input logic              mode_i,
   input logic [ADDR_W-1:0] burst_addr_o,
   input logic [ADDR_W-1:0] beat_o
);
   logic seen_edge;
   always_ff @(posedge clk) seen_edge <= 1'b1;

   assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
      (seen_edge && !$past(rst) && $past(load_i)) |->
         (burst_addr_o == $past(start_addr_i) && beat_o == '0));

   assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
      (seen_edge && !$past(rst) && $past(load_i) && !$past(adv_n_i)) |->
         (beat_o == '0));

   assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (seen_edge && !$past(rst) && !$past(load_i) && $past(adv_n_i)
       && $past(mode_i) == mode_i) |->
         ($stable(beat_o) && $stable(burst_addr_o)));

   assert_step_one_R9: assert property (@(posedge clk) disable iff (rst)
      (seen_edge && !$past(rst) && !$past(load_i) && !$past(adv_n_i)) |->
         (beat_o == ADDR_W'($past(beat_o) + 1'b1)));

   assert_flip_order_R4: assert property (@(posedge clk) disable iff (rst)
      (seen_edge && !$past(rst) && !$past(load_i) && mode_i && $past(mode_i)) |->
         ((burst_addr_o ^ $past(burst_addr_o)) == (beat_o ^ $past(beat_o))));

   assert_wrap_order_R5: assert property (@(posedge clk) disable iff (rst)
      (seen_edge && !$past(rst) && !$past(load_i) && !mode_i && !$past(mode_i)) |->
         (ADDR_W'(burst_addr_o - $past(burst_addr_o)) ==
          ADDR_W'(beat_o - $past(beat_o))));
endmodule

bind burst_seq_gen burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_burst_seq_gen.sv
module tb_burst_seq_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load_i = 1'b0;
   logic [1:0] start_addr_i = 2'd0;
   logic       adv_n_i = 1'b1;
   logic       mode_i = 1'b1;
   logic [1:0] burst_addr_o;
   logic [1:0] beat_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   burst_seq_gen dut (
      .clk(clk), .rst(rst), .load_i(load_i), .start_addr_i(start_addr_i),
      .adv_n_i(adv_n_i), .mode_i(mode_i),
      .burst_addr_o(burst_addr_o), .beat_o(beat_o)
   );

   // expected address: interleaved = start ^ beat, linear = (start + beat) mod 4
   function automatic logic [1:0] exp_addr(input logic [1:0] s, input logic [1:0] b,
                                           input logic m);
      return m ? (s ^ b) : 2'(s + b);
   endfunction

   task automatic check(input string req, input logic [1:0] a_exp, input logic [1:0] b_exp);
      n_run++;
      if (burst_addr_o !== a_exp || beat_o !== b_exp) begin
         n_fail++;
         $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
                  req, burst_addr_o, beat_o, a_exp, b_exp);
      end
   endtask

   // drive at the falling edge, sample 2 ns after the following rising edge
   task automatic cyc(input logic ld, input logic [1:0] sa, input logic adv_n);
      @(negedge clk);
      load_i = ld; start_addr_i = sa; adv_n_i = adv_n;
      @(posedge clk);
      #2;
   endtask

   task automatic t_reset;
      rst = 1'b1;
      cyc(1'b0, 2'd0, 1'b1);
      cyc(1'b0, 2'd0, 1'b1);
      check("R1 reset", 2'd0, 2'd0);
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_order(input logic m, input string req);
      mode_i = m;
      for (int s = 0; s < 4; s++) begin
         cyc(1'b1, 2'(s), 1'b1);
         check("R2 load", 2'(s), 2'd0);
         for (int b = 1; b < 4; b++) begin
            cyc(1'b0, 2'd0, 1'b0);
            check({req, " R9 step"}, exp_addr(2'(s), 2'(b), m), 2'(b));
         end
         cyc(1'b0, 2'd0, 1'b0);
         check("R7 wrap", 2'(s), 2'd0);
      end
   endtask

   task automatic t_wait;
      mode_i = 1'b0;
      cyc(1'b1, 2'd2, 1'b1);
      cyc(1'b0, 2'd0, 1'b0);
      check("R5 linear", 2'd3, 2'd1);
      cyc(1'b0, 2'd1, 1'b1);
      check("R6 wait", 2'd3, 2'd1);
      cyc(1'b0, 2'd3, 1'b1);
      check("R6 wait", 2'd3, 2'd1);
      cyc(1'b0, 2'd0, 1'b0);
      check("R5 after wait", 2'd0, 2'd2);
   endtask

   task automatic t_override;
      mode_i = 1'b1;
      cyc(1'b1, 2'd1, 1'b1);
      cyc(1'b0, 2'd0, 1'b0);
      cyc(1'b0, 2'd0, 1'b0);
      check("R4 mid burst", 2'd3, 2'd2);
      cyc(1'b1, 2'd3, 1'b0);
      check("R3 override", 2'd3, 2'd0);
      cyc(1'b0, 2'd0, 1'b0);
      check("R3 restart step", 2'd2, 2'd1);
   endtask

   task automatic t_mode_switch;
      mode_i = 1'b1;
      cyc(1'b1, 2'd1, 1'b1);
      cyc(1'b0, 2'd0, 1'b0);
      check("R4 beat1", 2'd0, 2'd1);
      @(negedge clk); adv_n_i = 1'b1; mode_i = 1'b0;
      #1;
      check("R8 to linear", 2'd2, 2'd1);
      #2; mode_i = 1'b1;
      #1;
      check("R8 back to interleaved", 2'd0, 2'd1);
   endtask

   task automatic t_reset_mid;
      mode_i = 1'b0;
      cyc(1'b1, 2'd3, 1'b1);
      cyc(1'b0, 2'd0, 1'b0);
      check("R5 start3", 2'd0, 2'd1);
      @(negedge clk); rst = 1'b1; adv_n_i = 1'b0;
      @(posedge clk); #2;
      check("R1 reset mid burst", 2'd0, 2'd0);
      @(negedge clk); rst = 1'b0; adv_n_i = 1'b1;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_order(1'b1, "R4 interleaved");
      t_order(1'b0, "R5 linear");
      t_wait();
      t_override();
      t_mode_switch();
      t_reset_mid();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule